// File: doc/BRIEF.md
# Digital PLL Mode Controller with Holdover Averaging

This block is the operating-mode controller of a digital phase-locked loop. It decides whether the loop is running without a reference, pulling in to a reference, tracking it, or coasting in holdover. It makes that decision from the reference-valid flag, a reference-switch event and the lock detector. It tells the loop filter which of two bandwidth settings to apply: a wide one while pulling in and a narrow one once tracking. When the active reference changes while the loop is running, it raises a one-cycle phase build-out strobe. The phase detector uses that strobe to absorb the phase step instead of passing it to the output.

While locked, the controller takes the loop's frequency-control word every cycle and keeps three running averages over short, medium and long windows. Each window length is a power-of-two sample count set by a parameter, so a simulation can use short windows and silicon can use windows of seconds and hours. Averaging runs only in the locked state. The averages stop changing as soon as the loop leaves that state, so a reference that is failing cannot pull them off. The holdover frequency word always presents the best average that is ready, falling back to a fixed free-run word.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: During and after synchronous reset (`rst` high), `dpll_state` is free-run (code 0), `bw_locked` is 0, `pbo_strobe` is 0 and `hold_word` equals the `FREERUN_WORD` parameter.
- R2: State codes are 0 free-run, 1 acquisition, 2 locked, 3 holdover. In free-run, a high `ref_valid` at a clock edge moves the state to acquisition at that edge; otherwise the state stays free-run.
- R3: In acquisition with `ref_valid` high, the state moves to locked on the edge that completes `LOCK_COUNT` consecutive edges with `lock_det` high; any edge with `lock_det` low restarts the count.
- R4: `bw_locked` is 1 (narrow, locked bandwidth) exactly while the state is locked and 0 (wide, acquisition bandwidth) in every other state.
- R5: In acquisition or locked, an edge with `ref_valid` low moves the state to holdover at that edge.
- R6: In holdover, an edge with `ref_valid` high moves the state to acquisition, never straight to locked.
- R7: In locked with `ref_valid` high, an edge with `lock_det` low returns the state to acquisition.
- R8: `pbo_strobe` is high for the cycle after an edge where `ref_switch`, `ref_valid` are high and the state is acquisition or locked, and low otherwise; a switch does not change the state.
- R9: Window k (k = short, medium, long, holding 2^`WIN_LOG2_*` samples) sums `freq_word` on each edge where the state is locked, and at the edge that adds its last sample it stores the truncated mean and marks itself complete.
- R10: `hold_word` is registered one edge after the window results and shows the long average if complete, else the medium one if complete, else the short one if complete, else `FREERUN_WORD`.
- R11: Outside the locked state no window sum, sample count or average changes, so `hold_word` stays constant through holdover from its second cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_valid | input | 1 | Selected reference is usable |
| ref_switch | input | 1 | One-cycle event: selected reference changed |
| lock_det | input | 1 | Lock detector indication from the loop |
| freq_word | input | FW | Current frequency-control word of the loop |
| dpll_state | output | 2 | Mode code (0 free-run, 1 acquisition, 2 locked, 3 holdover) |
| bw_locked | output | 1 | 1 selects locked bandwidth, 0 acquisition bandwidth |
| hold_word | output | FW | Holdover frequency word |
| pbo_strobe | output | 1 | Phase build-out request, one cycle per qualifying switch |

## Verification
A wrong mode register shows up on `dpll_state` and `bw_locked` one edge after the input that should have moved it, so the bench compares both against its model every cycle. Because of that, a lost or early lock transition is caught within a single cycle. A corrupted window sum or sample count stays hidden until that window completes and its mean reaches `hold_word` one edge later. The stimulus therefore runs each window to completion several times, with a varying frequency word, and interleaves holdover periods so that the freeze and the fallback order are both visible on the output.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_LOCK = 2'd2,
    ST_HOLD = 2'd3
  } dpll_state_e;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
  import dpll_mode_pkg::*;
#(
  parameter int LOCK_COUNT = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        ref_valid,
  input  logic        ref_switch,
  input  logic        lock_det,
  output dpll_state_e state_q,
  output logic        bw_q,
  output logic        pbo_q
);
  localparam int CW = $clog2(LOCK_COUNT + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(LOCK_COUNT - 1);

  dpll_state_e state_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = '0;
    unique case (state_q)
      ST_FREE: if (ref_valid) state_d = ST_ACQ;
      ST_ACQ: begin
        if (!ref_valid) begin
          state_d = ST_HOLD;
        end else if (lock_det) begin
          if (cnt_q == CNT_LAST) state_d = ST_LOCK;
          else cnt_d = cnt_q + 1'b1;
        end
      end
      ST_LOCK: begin
        if (!ref_valid)     state_d = ST_HOLD;
        else if (!lock_det) state_d = ST_ACQ;
      end
      ST_HOLD: if (ref_valid) state_d = ST_ACQ;
      default: state_d = ST_FREE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_FREE;
      cnt_q   <= '0;
      bw_q    <= 1'b0;
      pbo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      bw_q    <= (state_d == ST_LOCK);
      pbo_q   <= ref_switch && ref_valid &&
                 ((state_q == ST_ACQ) || (state_q == ST_LOCK));
    end
  end
endmodule

// File: rtl/holdover_window.sv
module holdover_window #(
  parameter int FW       = 32,
  parameter int WIN_LOG2 = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          sample_en,
  input  logic [FW-1:0] freq_word,
  output logic [FW-1:0] avg_word,
  output logic          avg_valid
);
  localparam int AW = FW + WIN_LOG2;

  logic [AW-1:0]       acc_q;
  logic [WIN_LOG2-1:0] cnt_q;
  logic [AW-1:0]       sum;

  assign sum = acc_q + AW'(freq_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      cnt_q     <= '0;
      avg_word  <= '0;
      avg_valid <= 1'b0;
    end else if (sample_en) begin
      if (&cnt_q) begin
        avg_word  <= sum[AW-1:WIN_LOG2];
        avg_valid <= 1'b1;
        acc_q     <= '0;
        cnt_q     <= '0;
      end else begin
        acc_q <= sum;
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/holdover_select.sv
module holdover_select #(
  parameter int            FW           = 32,
  parameter int            NWIN         = 3,
  parameter logic [FW-1:0] FREERUN_WORD = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NWIN*FW-1:0] avg_flat,
  input  logic [NWIN-1:0]    avg_valid,
  output logic [FW-1:0]      hold_word
);
  logic [FW-1:0] pick;

  always_comb begin
    pick = FREERUN_WORD;
    for (int i = 0; i < NWIN; i++) begin
      if (avg_valid[i]) pick = avg_flat[i*FW +: FW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) hold_word <= FREERUN_WORD;
    else     hold_word <= pick;
  end
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
  import dpll_mode_pkg::*;
#(
  parameter int            FW             = 32,
  parameter int            LOCK_COUNT     = 16,
  parameter int            WIN_LOG2_SHORT = 4,
  parameter int            WIN_LOG2_MID   = 6,
  parameter int            WIN_LOG2_LONG  = 8,
  parameter logic [FW-1:0] FREERUN_WORD   = 32'h8000_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ref_valid,
  input  logic          ref_switch,
  input  logic          lock_det,
  input  logic [FW-1:0] freq_word,
  output logic [1:0]    dpll_state,
  output logic          bw_locked,
  output logic [FW-1:0] hold_word,
  output logic          pbo_strobe
);
  localparam int NWIN = 3;

  dpll_state_e        state_q;
  logic [NWIN*FW-1:0] avg_flat;
  logic [NWIN-1:0]    avg_valid;
  logic               sample_en;

  dpll_mode_fsm #(.LOCK_COUNT(LOCK_COUNT)) i_fsm (
    .clk       (clk),
    .rst       (rst),
    .ref_valid (ref_valid),
    .ref_switch(ref_switch),
    .lock_det  (lock_det),
    .state_q   (state_q),
    .bw_q      (bw_locked),
    .pbo_q     (pbo_strobe)
  );

  assign sample_en  = (state_q == ST_LOCK);
  assign dpll_state = state_q;

  for (genvar g = 0; g < NWIN; g++) begin : g_win
    localparam int LG = (g == 0) ? WIN_LOG2_SHORT :
                        (g == 1) ? WIN_LOG2_MID : WIN_LOG2_LONG;
    holdover_window #(.FW(FW), .WIN_LOG2(LG)) i_win (
      .clk      (clk),
      .rst      (rst),
      .sample_en(sample_en),
      .freq_word(freq_word),
      .avg_word (avg_flat[g*FW +: FW]),
      .avg_valid(avg_valid[g])
    );
  end

  holdover_select #(.FW(FW), .NWIN(NWIN), .FREERUN_WORD(FREERUN_WORD)) i_sel (
    .clk      (clk),
    .rst      (rst),
    .avg_flat (avg_flat),
    .avg_valid(avg_valid),
    .hold_word(hold_word)
  );
endmodule

// File: rtl/dpll_mode_chk.sv
module dpll_mode_chk #(
  parameter int FW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          ref_valid,
  input logic          ref_switch,
  input logic [1:0]    dpll_state,
  input logic          bw_locked,
  input logic [FW-1:0] hold_word,
  input logic          pbo_strobe
);
  AST_FREE_TO_ACQ: assert property (@(posedge clk) disable iff (rst)
    (dpll_state == 2'd0 && ref_valid) |=> dpll_state == 2'd1); // R2
  AST_LOCK_FROM_ACQ: assert property (@(posedge clk) disable iff (rst)
    (dpll_state == 2'd2 && $past(dpll_state) != 2'd2) |-> $past(dpll_state) == 2'd1); // R3
  AST_BW_MATCH: assert property (@(posedge clk) disable iff (rst)
    bw_locked == (dpll_state == 2'd2)); // R4
  AST_LOSS_TO_HOLD: assert property (@(posedge clk) disable iff (rst)
    ((dpll_state == 2'd1 || dpll_state == 2'd2) && !ref_valid) |=> dpll_state == 2'd3); // R5
  AST_HOLD_EXIT_ACQ: assert property (@(posedge clk) disable iff (rst)
    (dpll_state == 2'd3 && ref_valid) |=> dpll_state == 2'd1); // R6
  AST_PBO_CAUSE: assert property (@(posedge clk) disable iff (rst)
    pbo_strobe |-> $past(ref_switch)); // R8
  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (dpll_state == 2'd3 && $past(dpll_state) == 2'd3) |=> $stable(hold_word)); // R11
endmodule

bind dpll_mode_ctrl dpll_mode_chk #(.FW(FW)) i_chk (
  .clk       (clk),
  .rst       (rst),
  .ref_valid (ref_valid),
  .ref_switch(ref_switch),
  .dpll_state(dpll_state),
  .bw_locked (bw_locked),
  .hold_word (hold_word),
  .pbo_strobe(pbo_strobe)
);

// File: tb/test_dpll_mode_ctrl.sv
module test_dpll_mode_ctrl;
  localparam int FW = 32;
  localparam int LOCKN = 6;
  localparam int L0 = 2, L1 = 3, L2 = 4;
  localparam logic [FW-1:0] FREE_W = 32'h0012_3456;

  logic clk = 1'b0, rst = 1'b1;
  logic ref_valid = 1'b0, ref_switch = 1'b0, lock_det = 1'b0;
  logic [FW-1:0] freq_word = '0;
  logic [1:0] dpll_state;
  logic bw_locked, pbo_strobe;
  logic [FW-1:0] hold_word;

  always #4 clk = ~clk;

  dpll_mode_ctrl #(.FW(FW), .LOCK_COUNT(LOCKN), .WIN_LOG2_SHORT(L0),
    .WIN_LOG2_MID(L1), .WIN_LOG2_LONG(L2), .FREERUN_WORD(FREE_W)) i_dpll_mode_ctrl (
    .clk(clk), .rst(rst), .ref_valid(ref_valid), .ref_switch(ref_switch),
    .lock_det(lock_det), .freq_word(freq_word), .dpll_state(dpll_state),
    .bw_locked(bw_locked), .hold_word(hold_word), .pbo_strobe(pbo_strobe));

  int checks = 0, failures = 0, cycles = 0;
  string tag = "R1";
  bit started = 1'b0;

  // behavioural model
  int m_state, m_cnt, m_pbo, m_bw;
  longint m_hold;
  longint w_acc[3], w_avg[3];
  int w_n[3], w_done[3];
  int w_len[3] = '{1 << L0, 1 << L1, 1 << L2};

  always @(posedge clk) begin
    cycles++;
    started = 1'b1;
    if (rst) begin
      m_state = 0; m_cnt = 0; m_pbo = 0; m_bw = 0; m_hold = FREE_W;
      for (int k = 0; k < 3; k++) begin
        w_acc[k] = 0; w_avg[k] = 0; w_n[k] = 0; w_done[k] = 0;
      end
    end else begin
      longint h;
      int ns, old;
      h = FREE_W;
      for (int k = 0; k < 3; k++) if (w_done[k] != 0) h = w_avg[k];
      m_hold = h;
      old = m_state;
      if (old == 2) begin
        for (int k = 0; k < 3; k++) begin
          w_acc[k] += freq_word;
          w_n[k]++;
          if (w_n[k] == w_len[k]) begin
            w_avg[k] = w_acc[k] / w_len[k];
            w_done[k] = 1; w_acc[k] = 0; w_n[k] = 0;
          end
        end
      end
      m_pbo = (ref_switch && ref_valid && (old == 1 || old == 2)) ? 1 : 0;
      ns = old;
      if (old == 0) begin
        if (ref_valid) ns = 1;
      end else if (old == 1) begin
        if (!ref_valid) ns = 3;
        else if (lock_det) begin
          m_cnt++;
          if (m_cnt == LOCKN) ns = 2;
        end else m_cnt = 0;
      end else if (old == 2) begin
        if (!ref_valid) ns = 3;
        else if (!lock_det) ns = 1;
      end else if (ref_valid) ns = 1;
      if (ns != 1) m_cnt = 0;
      if (old != 1 && ns == 1) m_cnt = 0;
      m_state = ns;
      m_bw = (ns == 2) ? 1 : 0;
    end
  end

  task automatic chk(input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk("state", dpll_state, m_state);
      chk("bw_locked R4", bw_locked, m_bw);
      chk("pbo_strobe", pbo_strobe, m_pbo);
      chk("hold_word", hold_word, m_hold);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
    finish_run();
  end

  int seed = 7;
  always @(negedge clk) begin
    #2;
    seed = (seed * 37 + 11) % 101;
    freq_word <= 32'd5000 + 32'(seed);
  end

  initial begin
    cyc(3);
    tag = "R1"; // reset values
    chk("reset state R1", dpll_state, 0);
    chk("reset hold R1", hold_word, FREE_W);
    rst = 1'b0;
    tag = "R2"; cyc(3);                   // no reference: stay free-run
    chk("free R2", dpll_state, 0);
    ref_valid = 1'b1; cyc(1);
    chk("acq R2", dpll_state, 1);
    tag = "R3"; cyc(2);
    lock_det = 1'b1; cyc(LOCKN - 2);
    lock_det = 1'b0; cyc(1);               // restart count
    chk("still acq R3", dpll_state, 1);
    lock_det = 1'b1; cyc(LOCKN);
    chk("locked R3", dpll_state, 2);
    tag = "R8"; ref_switch = 1'b1; cyc(1); ref_switch = 1'b0;
    chk("pbo R8", pbo_strobe, 1);
    chk("state kept R8", dpll_state, 2);
    tag = "R9"; cyc(5);                    // short window completes
    tag = "R5"; ref_valid = 1'b0; cyc(1);
    chk("hold R5", dpll_state, 3);
    tag = "R10"; cyc(3);
    tag = "R8"; ref_switch = 1'b1; cyc(1); ref_switch = 1'b0;
    chk("no pbo in hold R8", pbo_strobe, 0);
    tag = "R6"; ref_valid = 1'b1; cyc(1);
    chk("back to acq R6", dpll_state, 1);
    tag = "R9"; cyc(LOCKN + 40);           // all windows complete
    tag = "R7"; lock_det = 1'b0; cyc(1);
    chk("lock lost R7", dpll_state, 1);
    lock_det = 1'b1; cyc(LOCKN + 21);
    tag = "R11"; ref_valid = 1'b0; cyc(25); // frozen averages
    tag = "R10"; ref_valid = 1'b1; cyc(LOCKN + 3);
    tag = "R5"; ref_valid = 1'b0; cyc(4);
    cyc(2);
    finish_run();
  end
endmodule